// File: doc/BRIEF.md
# Line-Counted Vertical Event Generator

This block produces two delayed timing strobes for a raster display. Each field begins on the rising edge of the vertical sync input. The block then counts line pulses from that edge. A vertical flyback start strobe fires once the count reaches one programmed line delay. A correction map start strobe fires once the count reaches a second, independent delay. Changing the flyback delay moves the vertical phase of the picture.

A small parallel register port stands in for a serial control bus. It stages five commanded values: a sync priority selection, the two line delays, and the left and right blanking positions. The staged values are copied into active copies only on a vertical sync rising edge, so timing never changes in the middle of a field. The blanking positions and the priority selection are driven out from the active copies.

A status word collects the active priority, the active blanking positions and two per-field "strobe already fired" flags. When any bit of that word changes, a one-clock interrupt pulse is raised.

Each of the two channels is a three-state machine:
- WAIT (after reset) goes to ARMED on a sync edge.
- ARMED goes to FIRED on a matching line pulse, which issues the strobe. A sync edge keeps it in ARMED and restarts it.
- FIRED goes back to ARMED on a sync edge.

Top module: `vline_event_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, both strobes are low and the interrupt is low. The priority and blanking outputs are zero, and every register reads back zero.
- R2: The register addresses are fixed:
    - 0 holds the priority selection (bits 1:0 only; upper bits are stored as zero).
    - 1 holds the flyback delay.
    - 2 holds the map delay.
    - 3 holds the left blank position.
    - 4 holds the right blank position.

  `rd_data` combinationally returns the staged value at `rd_addr`. Addresses 5 to 7 read zero, and writes to them change nothing.
- R3: The line count restarts at zero on every vsync rising edge. The count is 0 for the first line pulse after that edge. `flyback_stb` is high for exactly one clock, in the cycle after the line pulse whose count equals the active flyback delay.
- R4: `map_stb` follows the same rule as R3, using the active map delay, independently of the flyback channel.
- R5: A delay of zero fires its strobe on the first line pulse after the vsync edge.
- R6: Each strobe fires at most once per field. Later line pulses produce no strobe until the next vsync rising edge.
- R7: Register writes do not change the outputs or the delays in use. The new values become active on the next vsync rising edge.
- R8: A vsync rising edge in the middle of a field restarts the count and re-arms both channels. A line pulse in the same cycle as the vsync edge is not counted.
- R9: `irq` is high for the one cycle in which the status word first holds a new value. The status word is made of the priority, left blank, right blank and the two fired flags. The fired flags are set along with their strobe and cleared at the vsync edge.
- R10: A delay equal to or greater than the number of line pulses in the field produces no strobe in that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_in | input | 1 | Regenerated vertical sync level, synchronous to clk |
| line_pls | input | 1 | One-clock pulse per horizontal line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 10 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 10 | Staged value at rd_addr |
| flyback_stb | output | 1 | Vertical flyback start strobe |
| map_stb | output | 1 | Correction map start strobe |
| sync_prio | output | 2 | Active sync priority selection |
| lblank_pos | output | 10 | Active left blanking position |
| rblank_pos | output | 10 | Active right blanking position |
| irq | output | 1 | Status change interrupt pulse |

## Verification
The bench runs a table of fields. Each row sets a flyback delay, a map delay and a line count for the field. Equal delays check that the two channels fire together. Very different delays check that they are independent. A delay of zero checks the first-pulse case. Delays at or past the field length check that no strobe fires.

Directed cases cover several situations:
- A line pulse that coincides with the sync edge, which separates "ignored" from "counted as line 0".
- A sync edge in the middle of a field, followed by a delay write, which separates restart and re-arm from leakage of staged values.
- A blanking write, which shows that outputs and the interrupt change only at the next sync edge.

// File: rtl/vevt_pkg.sv
package vevt_pkg;
    localparam int VE_DATA_W = 10;
    localparam int VE_ADDR_W = 3;
    localparam int VE_PRIO_W = 2;
    localparam int VE_NREG   = 5;

    // register indices; the channel wiring depends on these
    localparam int REG_PRIO = 0;
    localparam int REG_FLY  = 1;
    localparam int REG_MAP  = 2;
    localparam int REG_LBL  = 3;
    localparam int REG_RBL  = 4;

    typedef enum logic [1:0] {
        CH_WAIT  = 2'd0,
        CH_ARMED = 2'd1,
        CH_FIRED = 2'd2
    } ch_state_e;
endpackage

// File: rtl/vevt_regbank.sv
module vevt_regbank #(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 3,
    parameter int PRIO_W = 2,
    parameter int NREG   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              apply,
    output logic [DATA_W-1:0] rd_data,
    output logic [PRIO_W-1:0] act_prio,
    output logic [DATA_W-1:0] act_fly,
    output logic [DATA_W-1:0] act_map,
    output logic [DATA_W-1:0] act_lbl,
    output logic [DATA_W-1:0] act_rbl
);
    import vevt_pkg::*;

    localparam logic [DATA_W-1:0] PRIO_MASK = DATA_W'((1 << PRIO_W) - 1);

    logic [DATA_W-1:0] stg [NREG];
    logic [DATA_W-1:0] act [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK = (i == REG_PRIO) ? PRIO_MASK : '1;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[i] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                stg[i] <= wr_data & MASK;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act[i] <= '0;
            end else if (apply) begin
                act[i] <= stg[i];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = stg[i];
            end
        end
    end

    assign act_prio = act[REG_PRIO][PRIO_W-1:0];
    assign act_fly  = act[REG_FLY];
    assign act_map  = act[REG_MAP];
    assign act_lbl  = act[REG_LBL];
    assign act_rbl  = act[REG_RBL];

    // R7: active copies only move on an apply cycle
    p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(act_lbl) && $stable(act_rbl) && $stable(act_fly) && $stable(act_map)));
endmodule

// File: rtl/vevt_line_cnt.sv
module vevt_line_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic             line_i,
    output logic             vs_rise_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic vs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
        end else begin
            vs_q <= vsync_i;
        end
    end

    assign vs_rise_o = vsync_i & ~vs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (vs_rise_o) begin
            cnt_o <= '0;
        end else if (line_i && (cnt_o != '1)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R3 / R8: count restarts on every sync edge, line pulse ignored there
    p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise_o |=> (cnt_o == '0));
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_rise_o && !line_i) |=> $stable(cnt_o));
endmodule

// File: rtl/vevt_channel.sv
module vevt_channel #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_rise_i,
    input  logic             line_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] dly_i,
    output logic             stb_o,
    output logic             fired_o
);
    import vevt_pkg::*;

    ch_state_e state_q, state_d;
    logic      fire;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and fire decision
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            CH_WAIT: begin
                if (vs_rise_i) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (vs_rise_i) begin
                    state_d = CH_ARMED;
                end else if (line_i && (cnt_i == dly_i)) begin
                    fire    = 1'b1;
                    state_d = CH_FIRED;
                end
            end
            CH_FIRED: begin
                if (vs_rise_i) state_d = CH_ARMED;
            end
            default: state_d = CH_WAIT;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_o <= 1'b0;
        end else begin
            stb_o <= fire;
        end
    end

    assign fired_o = (state_q == CH_FIRED);

    // R3: single-clock strobe
    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);
    // R3: strobe only follows a line pulse
    p_stb_after_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> $past(line_i));
    // R6: no second strobe while fired and no sync edge
    p_once_per_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_o && !vs_rise_i) |=> !stb_o);
endmodule

// File: rtl/vline_event_gen.sv
module vline_event_gen #(
    parameter int DATA_W = vevt_pkg::VE_DATA_W,
    parameter int ADDR_W = vevt_pkg::VE_ADDR_W,
    parameter int PRIO_W = vevt_pkg::VE_PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              line_pls,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              flyback_stb,
    output logic              map_stb,
    output logic [PRIO_W-1:0] sync_prio,
    output logic [DATA_W-1:0] lblank_pos,
    output logic [DATA_W-1:0] rblank_pos,
    output logic              irq
);
    import vevt_pkg::*;

    localparam int NCH  = 2;
    localparam int ST_W = PRIO_W + 2 * DATA_W + NCH;

    logic              vs_rise;
    logic [DATA_W-1:0] line_cnt;
    logic [DATA_W-1:0] act_fly, act_map;
    logic [DATA_W-1:0] dly_arr [NCH];
    logic [NCH-1:0]    stb_v, fired_v;
    logic [ST_W-1:0]   status, status_prev;

    vevt_regbank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .NREG(VE_NREG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .apply(vs_rise), .rd_data(rd_data),
        .act_prio(sync_prio), .act_fly(act_fly), .act_map(act_map),
        .act_lbl(lblank_pos), .act_rbl(rblank_pos)
    );

    vevt_line_cnt #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_in), .line_i(line_pls),
        .vs_rise_o(vs_rise), .cnt_o(line_cnt)
    );

    assign dly_arr[0] = act_fly;
    assign dly_arr[1] = act_map;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        vevt_channel #(.CNT_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .vs_rise_i(vs_rise), .line_i(line_pls),
            .cnt_i(line_cnt), .dly_i(dly_arr[c]),
            .stb_o(stb_v[c]), .fired_o(fired_v[c])
        );
    end

    assign flyback_stb = stb_v[0];
    assign map_stb     = stb_v[1];

    assign status = {sync_prio, lblank_pos, rblank_pos, fired_v};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_prev <= '0;
        end else begin
            status_prev <= status;
        end
    end

    assign irq = (status != status_prev);

    // R9: an output value change always comes with the interrupt
    p_irq_on_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(lblank_pos) || !$stable(rblank_pos) || !$stable(sync_prio)) |-> irq);
    p_irq_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flyback_stb || map_stb) |-> irq);
    // R7: blanking outputs move only right after a sync edge
    p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> ($stable(lblank_pos) && $stable(rblank_pos)));
endmodule

// File: tb/vline_event_gen_tb_top.sv
`timescale 1ns/1ps
module vline_event_gen_tb_top;
    localparam int DW = 10;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vsync_in = 1'b0, line_pls = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data, lblank_pos, rblank_pos;
    logic [1:0]    sync_prio;
    logic          flyback_stb, map_stb, irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    vline_event_gen dut_i (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .line_pls(line_pls),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .flyback_stb(flyback_stb), .map_stb(map_stb),
        .sync_prio(sync_prio), .lblank_pos(lblank_pos), .rblank_pos(rblank_pos),
        .irq(irq)
    );

    // field table: flyback delay, map delay, line pulses in the field
    localparam int NV = 6;
    localparam int V_FLY [NV] = '{0, 2, 4, 6, 3, 7};
    localparam int V_MAP [NV] = '{0, 5, 1, 9, 3, 0};
    localparam int V_LN  [NV] = '{3, 7, 6, 5, 4, 8};

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = DW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(string req, int addr, int exp);
        rd_addr = AW'(addr);
        #0.5;
        check(req, int'(rd_data), exp);
    endtask

    task automatic vsync_edge();
        @(negedge clk);
        vsync_in = 1'b1;
        @(negedge clk);
        vsync_in = 1'b0;
    endtask

    task automatic line_pulse(string req, bit ef, bit em);
        @(negedge clk);
        line_pls = 1'b1;
        @(negedge clk);
        line_pls = 1'b0;
        check({req, " flyback strobe"}, int'(flyback_stb), int'(ef));
        check({req, " map strobe"}, int'(map_stb), int'(em));
        check({req, " R9 irq with strobe"}, int'(irq), int'(ef | em));
        @(negedge clk);
        check({req, " R3 strobe width"}, int'(flyback_stb | map_stb), 0);
    endtask

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        check("R1 flyback in reset", int'(flyback_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flyback", int'(flyback_stb), 0);
        check("R1 map", int'(map_stb), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 lblank", int'(lblank_pos), 0);
        check("R1 rblank", int'(rblank_pos), 0);
        check("R1 prio", int'(sync_prio), 0);
        for (int a = 0; a < 8; a++) reg_read("R1 readback", a, 0);

        // R2 register map
        reg_write(0, 'h3FF);
        reg_read("R2 prio masked", 0, 3);
        reg_write(4, 'h123);
        reg_read("R2 right blank", 4, 'h123);
        reg_write(5, 'h2AA);
        reg_read("R2 unused addr", 5, 0);
        reg_read("R2 others kept", 4, 'h123);
        reg_read("R2 prio kept", 0, 3);

        // main table: R3 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            reg_write(1, V_FLY[v]);
            reg_write(2, V_MAP[v]);
            vsync_edge();
            for (int p = 0; p < V_LN[v]; p++) begin
                line_pulse($sformatf("R3/R4/R5/R6/R10 row%0d line%0d", v, p),
                           (p == V_FLY[v]), (p == V_MAP[v]));
            end
        end

        // R7 blank write takes effect at next sync only
        reg_write(3, 'h55);
        @(negedge clk);
        check("R7 lblank held", int'(lblank_pos), 0);
        check("R7 no irq before sync", int'(irq), 0);
        reg_read("R7 staged readback", 3, 'h55);
        vsync_edge();
        check("R7 lblank applied", int'(lblank_pos), 'h55);
        check("R9 irq at apply", int'(irq), 1);
        @(negedge clk);
        check("R9 irq one clock", int'(irq), 0);

        // R8 line pulse coincident with sync edge is not counted
        reg_write(1, 0);
        reg_write(2, 20);
        vsync_edge();
        @(negedge clk);
        vsync_in = 1'b1; line_pls = 1'b1;
        @(negedge clk);
        vsync_in = 1'b0; line_pls = 1'b0;
        check("R8 coincident pulse ignored", int'(flyback_stb), 0);
        line_pulse("R8 R5 first line after edge", 1'b1, 1'b0);

        // R8 mid-field restart; R7 delay write does not leak into the field
        reg_write(1, 3);
        vsync_edge();
        line_pulse("R8 before restart", 1'b0, 1'b0);
        line_pulse("R8 before restart", 1'b0, 1'b0);
        vsync_edge();
        reg_write(1, 0);
        line_pulse("R8 R7 after restart", 1'b0, 1'b0);
        line_pulse("R8 R7 after restart", 1'b0, 1'b0);
        line_pulse("R8 R7 after restart", 1'b0, 1'b0);
        line_pulse("R8 R7 restart fires", 1'b1, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule